// File: doc/BRIEF.md
# Coarse Interval Counter with Edge-Error Pulses

This block times the gap between a start event and a stop event against a reference clock. It counts the whole reference periods that fall inside the interval. It also emits two short pulses that carry the fractional parts the count cannot see. The first pulse runs from the start edge to the next rising reference edge. The second runs from the stop edge to the next rising reference edge. A downstream fine interpolator measures the width of each pulse. The true interval is then the count times the reference period, plus the start-side pulse width, minus the stop-side pulse width.

The control path sees start and stop only through a synchronizer chain, so it never acts on a metastable level. The error pulses come straight from the raw edges, so their widths keep the sub-period information. The counter saturates rather than wrapping, and a sticky flag reports the saturation. A stop that arrives while no measurement is running is ignored. A start that arrives during a measurement is also ignored.

Top module: `coarse_interval_meter`

## Requirements
- R1: `err_start_o` goes high at every rising edge of `start_i` and returns low at the next rising edge of `clk`, so it is always shorter than one clock period.
- R2: `err_stop_o` goes high at every rising edge of `stop_i` and returns low at the next rising edge of `clk`. This holds even when the stop is otherwise ignored.
- R3: When start and stop rise with exactly N rising clock edges strictly between them, and N ≤ 2^CNT_W−1, `coarse_cnt_o` reads N once `done_o` is high. The interval is then N·Tclk + width(err_start_o) − width(err_stop_o).
- R4: `done_o` is high for exactly one clock cycle. It rises on the third rising clock edge after the first clock edge that follows the stop edge, and the final count is valid in that same cycle.
- R5: If the interval holds more than 2^CNT_W−1 clock edges, the count stops at 2^CNT_W−1 (255 by default) and `ovf_o` goes high. A count of exactly 2^CNT_W−1 leaves `ovf_o` low.
- R6: When a start is accepted (the third rising clock edge after the first clock edge that follows the start edge), `coarse_cnt_o` is cleared to 0 and `ovf_o` is cleared.
- R7: A stop edge while no measurement is running produces no `done_o` and leaves `coarse_cnt_o` unchanged.
- R8: A new start edge during a running measurement neither restarts nor clears the count.
- R9: While `rst_n` is low, `coarse_cnt_o`, `done_o`, `ovf_o`, `err_start_o` and `err_stop_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Asynchronous start event, active on its rising edge |
| stop_i | input | 1 | Asynchronous stop event, active on its rising edge |
| coarse_cnt_o | output | CNT_W | Whole reference periods counted between start and stop |
| done_o | output | 1 | One-cycle pulse when the count is final |
| ovf_o | output | 1 | Sticky flag set when the count saturated |
| err_start_o | output | 1 | Fractional pulse from the start edge to the next clock edge |
| err_stop_o | output | 1 | Fractional pulse from the stop edge to the next clock edge |

## Verification
Interval lengths from 1 to 40 clock periods are each run with three pairs of start and stop phase offsets within the clock period. This shows that the count depends only on the number of enclosed clock edges and not on where inside a period the events fall. In the same runs, the error pulses are checked at their rise and just after the next clock edge. Lengths of 255, 256 and 300 periods separate the exact maximum count from saturation. A restart after saturation shows that the count and the flag are cleared when a start is accepted. A stop with no measurement running and a second start during a running measurement show that neither event disturbs the result.

// File: rtl/cim_pkg.sv
`timescale 1ns/1ps
package cim_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cim_state_e;
endpackage

// File: rtl/cim_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer followed by a rising-edge detector.
module cim_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[LAST];
    end
  end

  assign rise_o = chain_q[LAST] & ~last_q;
endmodule

// File: rtl/cim_err_pulse.sv
`timescale 1ns/1ps
// Fractional error pulse: a flop clocked by the raw event toggles, and a
// flop clocked by the reference clock follows it; their difference is high
// from the raw edge until the next reference edge.
module cim_err_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  output logic err_o
);
  logic tog_q;
  logic tog_d;
  logic seen_q;

  always_comb begin
    tog_d = ~tog_q;
  end

  always_ff @(posedge evt_i or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= tog_q;
  end

  assign err_o = tog_q ^ seen_q;
endmodule

// File: rtl/cim_coarse_ctrl.sv
`timescale 1ns/1ps
// Measurement state machine with a saturating coarse counter.
module cim_coarse_ctrl
  import cim_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_rise_i,
  input  logic             stop_rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cim_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             done_q, done_d;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ovf_d   = ovf_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_rise_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          ovf_d   = 1'b0;
        end
      end
      ST_RUN: begin
        if (at_max) ovf_d = 1'b1;
        else        cnt_d = cnt_q + 1'b1;
        if (stop_rise_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ovf_q   <= ovf_d;
      done_q  <= done_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  // R3
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !at_max) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && at_max) |=> (cnt_q == CNT_MAX));

  // R5
  ovf_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> at_max);

  // R7
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_rise_i) |=> (!done_q && $stable(cnt_q)));

  // R8
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && start_rise_i && !at_max) |=> (cnt_q != '0));
endmodule

// File: rtl/coarse_interval_meter.sv
`timescale 1ns/1ps
module coarse_interval_meter #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] coarse_cnt_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic             err_start_o,
  output logic             err_stop_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  logic [1:0] evt_raw;
  logic [1:0] evt_rise;
  logic [1:0] evt_err;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  assign evt_raw = {stop_i, start_i};

  for (genvar g = 0; g < 2; g++) begin : g_evt
    cim_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk    (clk),
      .rst_n  (rst_s_n),
      .async_i(evt_raw[g]),
      .rise_o (evt_rise[g])
    );
    cim_err_pulse i_err (
      .clk  (clk),
      .rst_n(rst_s_n),
      .evt_i(evt_raw[g]),
      .err_o(evt_err[g])
    );
  end

  cim_coarse_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start_rise_i(evt_rise[0]),
    .stop_rise_i (evt_rise[1]),
    .cnt_o       (coarse_cnt_o),
    .done_o      (done_o),
    .ovf_o       (ovf_o)
  );

  assign err_start_o = evt_err[0];
  assign err_stop_o  = evt_err[1];

  // R9
  always_comb begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!err_start_o && !err_stop_o && !done_o);
    end
  end
endmodule

// File: tb/test_coarse_interval_meter.sv
`timescale 1ns/1ps
module test_coarse_interval_meter;
  localparam int CNT_W = 8;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic             stop_i;
  logic [CNT_W-1:0] coarse_cnt_o;
  logic             done_o, ovf_o, err_start_o, err_stop_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  coarse_interval_meter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_coarse_interval_meter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .coarse_cnt_o(coarse_cnt_o), .done_o(done_o), .ovf_o(ovf_o),
    .err_start_o(err_start_o), .err_stop_o(err_stop_o)
  );

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // start at phase a after an edge, stop n periods later at phase b;
  // optional second start edge during the run (glitch_at > 0).
  task automatic measure(int n, int a, int b, int glitch_at);
    int exp_cnt;
    exp_cnt = (n > MAXV) ? MAXV : n;
    @(posedge clk);
    #a start_i = 1'b1;
    #1 check("R1 err_start rises", int'(err_start_o), 1);
    step();
    check("R1 err_start clears", int'(err_start_o), 0);
    for (int k = 2; k <= n; k++) begin
      step();
      if (k == 3) begin
        check("R6 count cleared on accept", int'(coarse_cnt_o), 0);
        check("R6 ovf cleared on accept", int'(ovf_o), 0);
      end
      if (glitch_at > 0 && k == glitch_at)     start_i = 1'b0;
      if (glitch_at > 0 && k == glitch_at + 3) start_i = 1'b1;
    end
    #(b - 1) stop_i = 1'b1;
    #1 check("R2 err_stop rises", int'(err_stop_o), 1);
    step();
    check("R2 err_stop clears", int'(err_stop_o), 0);
    check("R4 done not early", int'(done_o), 0);
    step();
    step();
    check("R4 done asserted", int'(done_o), 1);
    check(glitch_at > 0 ? "R8 count after restart attempt" : "R3 coarse count",
          int'(coarse_cnt_o), exp_cnt);
    check("R5 overflow flag", int'(ovf_o), int'(n > MAXV));
    step();
    check("R4 done single cycle", int'(done_o), 0);
    start_i = 1'b0;
    stop_i  = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int held;
    rst_n   = 1'b0;
    start_i = 1'b0;
    stop_i  = 1'b0;
    repeat (2) step();
    // R9
    check("R9 reset count", int'(coarse_cnt_o), 0);
    check("R9 reset done", int'(done_o), 0);
    check("R9 reset ovf", int'(ovf_o), 0);
    check("R9 reset err_start", int'(err_start_o), 0);
    check("R9 reset err_stop", int'(err_stop_o), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) step();

    // R3 sweep over lengths and phase offsets
    for (int n = 1; n <= 40; n++) begin
      measure(n, 3, 2, 0);
      measure(n, 11, 9, 0);
      measure(n, 18, 17, 0);
    end

    // R5 boundary and saturation
    measure(255, 5, 6, 0);
    measure(256, 5, 6, 0);
    measure(300, 14, 3, 0);
    // R6 restart after saturation
    measure(7, 4, 12, 0);

    // R7 stop while idle
    held = int'(coarse_cnt_o);
    @(posedge clk);
    #5 stop_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step();
      check("R7 no done on idle stop", int'(done_o), 0);
    end
    stop_i = 1'b0;
    repeat (3) step();
    check("R7 count unchanged", int'(coarse_cnt_o), held);

    // R8 second start during a run
    measure(30, 6, 8, 10);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule